// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port, pipelined synchronous memory. It has one bidirectional data bus, three chip selects, a global write line, per-byte write selects and an asynchronous output enable. The rising clock edge captures every control input, the word address and any write data. A read leaves through an output register, so its data appears on the bus in the clock period after the edge that captured it. An external burst address sequencer supplies the word address on a plain input port. This block does not include that sequencer.

At full size the array is 65536 words of 32 bits (`ADDR_W = 16`). The parameter defaults to a smaller depth. Each 8-bit lane is a separate array so that block RAM with byte enables can be inferred. A read that comes straight after a deselected cycle keeps the bus in high impedance for its first clock, whatever the output enable says. This lets several banks share one bus safely.

Top module: `sync_burst_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits, and a word written and later read back returns the written value.
- R2: A read whose inputs are captured at rising edge k drives its data during the period that begins at edge k+1, not earlier.
- R3: With `all_wr_n` high and `lane_wr_n` low, each low bit i of `lane_sel_n` writes bits [8i+7:8i] from the bus, and every other lane of that word keeps its old contents.
- R4: With `all_wr_n` low, all four lanes of the word are written and `lane_wr_n` and `lane_sel_n` have no effect.
- R5: A selected cycle with `all_wr_n` high is a write only when `lane_wr_n` is low and at least one bit of `lane_sel_n` is low; any other selected cycle is a read that changes no word and drives the bus.
- R6: A cycle is selected only when `sel0_n` = 0, `sel1` = 1 and `sel2_n` = 0 all hold; in any other combination no word is written, even with `all_wr_n` low.
- R7: After a deselected cycle captured at edge k, including any cycle captured under reset, the memory does not drive the bus from edge k+1 on.
- R8: A read captured right after a deselected cycle never drives the bus, even with `oe_n` low; a read captured right after a selected cycle does.
- R9: `oe_n` high places the bus in high impedance with no clock edge needed, and `oe_n` low lets pending read data onto the bus in the same way.
- R10: While the pins present a selected write, the memory does not drive any bit of the bus, even with `oe_n` low and read data pending.
- R11: A read issued in the cycle right after a write to the same word returns the newly written lanes merged with the untouched old lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every synchronous input is captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the control pipeline |
| word_addr | input | ADDR_W | Current word address from the burst sequencer |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Global write, active low; writes every lane |
| lane_wr_n | input | 1 | Byte-write enable, active low; qualifies `lane_sel_n` |
| lane_sel_n | input | LANES | Per-lane write selects, active low; bit i controls bits [8i+7:8i] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| data_io | inout | LANES*8 | Shared data bus: write data in, read data out |

## Verification
The bench uses a 16-word memory. It sweeps every word with whole-word writes, then every lane mask with per-byte writes, including the mask that writes nothing. It then tries a write under each of the seven inactive chip-select combinations. A design that mixes up lane order, lets an unselected lane through, or treats a half-enabled byte write as a write would corrupt words, and later reads show this. The bench also hunts the first read after a deselect, a read one cycle too early, and read data left driving into a following partial write. Because the bench leaves undriven lanes pulled low, any stray drive from the memory shows up as nonzero bits. It also flips the output enable between edges and reads a word back in the cycle right after writing it.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANE_W = 8;

  typedef struct packed {
    logic sel;
    logic wr;
  } sbs_ctl_t;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic              wr_now,
  output sbs_ctl_t          ctl_q,
  output logic [LANES-1:0]  we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q
);
  logic             sel_now;
  logic [LANES-1:0] lane_req;

  always_comb begin
    sel_now = !sel0_n && sel1 && !sel2_n;
    if (!all_wr_n) begin
      lane_req = '1;
    end else if (!lane_wr_n) begin
      lane_req = ~lane_sel_n;
    end else begin
      lane_req = '0;
    end
    wr_now = sel_now && (|lane_req);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      we_q  <= '0;
    end else begin
      ctl_q.sel <= sel_now;
      ctl_q.wr  <= wr_now;
      we_q      <= sel_now ? lane_req : '0;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= word_addr;
    din_q  <= bus_in;
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[l]) begin
        mem[addr] <= din[l*LANE_W +: LANE_W];
      end
      rd_q <= mem[addr];
    end

    assign dout[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sbs_out.sv
module sbs_out
  import sbs_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  sbs_ctl_t          ctl_q,
  input  logic              oe_n,
  input  logic              wr_now,
  input  logic [DATA_W-1:0] rd_data,
  output logic              drv_q,
  output logic              bus_en,
  output logic [DATA_W-1:0] bus_val
);
  logic sel_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev_q <= 1'b0;
      drv_q      <= 1'b0;
    end else begin
      sel_prev_q <= ctl_q.sel;
      drv_q      <= ctl_q.sel && !ctl_q.wr && sel_prev_q;
    end
  end

  assign bus_en  = drv_q && !oe_n && !wr_now;
  assign bus_val = rd_data;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              oe_n,
  inout  wire  [DATA_W-1:0] data_io
);
  sbs_ctl_t          ctl_q;
  logic              wr_now;
  logic [LANES-1:0]  we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic [DATA_W-1:0] rd_data;
  logic              drv_q;
  logic              bus_en;
  logic [DATA_W-1:0] bus_val;

  sbs_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk(clk), .rst(rst), .word_addr(word_addr),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .bus_in(data_io), .wr_now(wr_now), .ctl_q(ctl_q), .we_q(we_q),
    .addr_q(addr_q), .din_q(din_q)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
    .clk(clk), .we(we_q), .addr(addr_q), .din(din_q), .dout(rd_data)
  );

  sbs_out #(.LANES(LANES)) u_out (
    .clk(clk), .rst(rst), .ctl_q(ctl_q), .oe_n(oe_n), .wr_now(wr_now),
    .rd_data(rd_data), .drv_q(drv_q), .bus_en(bus_en), .bus_val(bus_val)
  );

  assign data_io = bus_en ? bus_val : 'z;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sel0_n,
  input logic             sel1,
  input logic             sel2_n,
  input logic             all_wr_n,
  input logic             oe_n,
  input logic             wr_now,
  input logic [LANES-1:0] we_q,
  input logic             drv_q,
  input logic             bus_en
);
  logic pins_sel;
  assign pins_sel = !sel0_n && sel1 && !sel2_n;

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (pins_sel && !all_wr_n) |=> (we_q == '1)); // R4

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!pins_sel) |=> (we_q == '0)); // R6

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pins_sel) |=> ##1 !drv_q); // R7

  AST_FIRST_READ_MASK: assert property (@(posedge clk) disable iff (rst)
    (pins_sel && !wr_now && !$past(pins_sel)) |=> ##1 !drv_q); // R8

  AST_WRITE_NO_READ_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_now |=> ##1 !drv_q); // R10

  always_comb begin
    if (!rst) begin
      AST_OE_RELEASE: assert (!(oe_n && bus_en)); // R9
      AST_WRITE_BUS_FREE: assert (!(wr_now && bus_en)); // R10
    end
  end
endmodule

bind sync_burst_sram sbs_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
  .all_wr_n(all_wr_n), .oe_n(oe_n), .wr_now(wr_now), .we_q(we_q),
  .drv_q(drv_q), .bus_en(bus_en)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb_top;
  localparam int AW    = 4;
  localparam int LN    = 4;
  localparam int DW    = LN * 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] word_addr = '0;
  logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic          all_wr_n = 1'b1, lane_wr_n = 1'b1;
  logic [LN-1:0] lane_sel_n = '1;
  logic          oe_n = 1'b1;
  logic [DW-1:0] tb_drv = '0;
  logic [DW-1:0] tb_msk = '0;
  wire  [DW-1:0] data_io;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] model [DEPTH];
  logic          pend_v [2];
  logic [DW-1:0] pend_d [2];
  logic          prev_sel = 1'b0;

  always #10 clk = ~clk;

  for (genvar b = 0; b < DW; b++) begin : g_bus
    assign data_io[b] = tb_msk[b] ? tb_drv[b] : 1'bz;
    pulldown (data_io[b]);
  end

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN)) dut_i (
    .clk(clk), .rst(rst), .word_addr(word_addr),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .oe_n(oe_n), .data_io(data_io)
  );

  function automatic logic [DW-1:0] fw(input int a);
    return (32'h9E37_79B9 * (a + 1)) ^ 32'h0F0F_1234;
  endfunction

  function automatic logic [DW-1:0] fb(input int a);
    return (32'h6A09_E667 * (a + 3)) ^ 32'h8181_8181;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One bus cycle: pins change 5 ns after a rising edge, the bus is sampled at the
  // falling edge. The sample shows the read issued two steps earlier.
  task automatic step(input string tag, input logic s0n, input logic s1, input logic s2n,
                      input logic gwn, input logic lwn, input logic [LN-1:0] lsn,
                      input logic oen, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit flip);
    logic          sel, wr, dv;
    logic [LN-1:0] req;
    logic [DW-1:0] dd, msk, exp;
    @(posedge clk);
    #5;
    sel = !s0n && s1 && !s2n;
    req = !gwn ? '1 : (!lwn ? ~lsn : '0);
    wr  = sel && (req != '0);
    msk = '0;
    if (wr) begin
      for (int l = 0; l < LN; l++) msk[l*8 +: 8] = {8{req[l]}};
    end
    sel0_n = s0n; sel1 = s1; sel2_n = s2n;
    all_wr_n = gwn; lane_wr_n = lwn; lane_sel_n = lsn;
    oe_n = oen; word_addr = a;
    tb_drv = d; tb_msk = msk;
    dv = pend_v[1];
    dd = pend_d[1];
    pend_v[1] = pend_v[0];
    pend_d[1] = pend_d[0];
    pend_v[0] = sel && !wr && prev_sel;
    pend_d[0] = model[a];
    if (wr) model[a] = (model[a] & ~msk) | (d & msk);
    prev_sel = sel;
    @(negedge clk);
    exp = (d & msk) | (~msk & ((dv && !oen && !wr) ? dd : '0));
    check(tag, data_io, exp);
    if (flip) begin
      oe_n = !oen;
      #2;
      exp = (d & msk) | (~msk & ((dv && oen && !wr) ? dd : '0));
      check("R9", data_io, exp);
    end
  endtask

  task automatic rd(input string tag, input int a, input logic oen = 1'b0, input bit flip = 0);
    step(tag, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '1, oen, AW'(a), '0, flip);
  endtask

  task automatic wrw(input string tag, input int a, input logic [DW-1:0] d);
    step(tag, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 1'b0, AW'(a), d, 0);
  endtask

  task automatic wrb(input string tag, input int a, input logic [LN-1:0] lsn, input logic [DW-1:0] d);
    step(tag, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, lsn, 1'b0, AW'(a), d, 0);
  endtask

  // Deselected cycle that also presents a global write attempt.
  task automatic dsl(input string tag, input logic [2:0] c, input int a = 0);
    step(tag, c[0], c[1], c[2], 1'b0, 1'b1, '1, 1'b0, AW'(a), 32'hDEAD_BEEF, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    pend_v[0] = 0; pend_v[1] = 0; pend_d[0] = '0; pend_d[1] = '0;

    // R7: reset state, bus released while reset is held
    for (int i = 0; i < 3; i++) step("R7", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '1, 1'b0, '0, '0, 0);
    @(posedge clk);
    #5 rst = 1'b0;

    // R8: first read after reset follows a deselected cycle, stays undriven
    rd("R8", 0);
    dsl("R8", 3'b111);
    dsl("R8", 3'b111);

    // R1: whole-word sweep over every address, then read back
    for (int a = 0; a < DEPTH; a++) wrw("R1", a, fw(a));
    for (int a = 0; a < DEPTH; a++) rd("R1", a);
    dsl("R1", 3'b111);
    dsl("R1", 3'b111);

    // R2: data appears in the second sample after the read step, not earlier
    wrw("R2", 3, 32'h1234_5678);
    rd("R2", 3);
    dsl("R2", 3'b111);   // write two steps back: nothing driven
    dsl("R2", 3'b111);   // read of word 3 now visible
    dsl("R2", 3'b111);   // deselect before it: bus released

    // R3: every lane mask, near-exhaustive, then read back
    for (int a = 0; a < DEPTH; a++) wrb("R3", a, LN'(a), fb(a));
    for (int a = 0; a < DEPTH; a++) rd("R3", a);

    // R5: half-enabled byte writes are reads and change nothing
    step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 1'b0, 4'd2, 32'hFFFF_FFFF, 0);
    step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 1'b0, 4'd2, 32'hFFFF_FFFF, 0);
    rd("R5", 2);
    rd("R5", 2);
    rd("R5", 2);

    // R4: global write overrides lane selects and byte-write enable
    step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 4'd5, 32'hA1B2_C3D4, 0);
    step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1010, 1'b0, 4'd6, 32'h5566_7788, 0);
    rd("R4", 5);
    rd("R4", 6);
    rd("R4", 6);
    rd("R4", 5);

    // R6: each inactive select combination blocks a global write
    for (int c = 0; c < 8; c++) begin
      if (c != 2) dsl("R6", 3'(c), c);
    end
    rd("R6", 0);
    for (int a = 0; a < 8; a++) rd("R6", a);
    rd("R6", 7);

    // R8: read after deselect masked, following read driven
    dsl("R8", 3'b000);
    rd("R8", 9);
    rd("R8", 10);
    rd("R8", 11);
    rd("R8", 12);

    // R9: output enable acts between edges
    rd("R9", 4);
    rd("R9", 5, 1'b0, 1);
    rd("R9", 6, 1'b1, 1);
    rd("R9", 7, 1'b0, 1);

    // R10: pending read data must not collide with a partial write
    rd("R10", 7);
    rd("R10", 8);
    wrb("R10", 9, 4'b1110, 32'hCAFE_F00D);
    wrb("R10", 11, 4'b0111, 32'h7700_0000);
    rd("R10", 9);
    rd("R10", 11);
    rd("R10", 9);

    // R11: read immediately after a write to the same word
    wrw("R11", 10, 32'h0BAD_F00D);
    rd("R11", 10);
    wrb("R11", 10, 4'b0101, 32'hEE11_DD22);
    rd("R11", 10);
    wrb("R11", 10, 4'b1100, 32'h3333_4444);
    rd("R11", 10);
    dsl("R11", 3'b111);
    dsl("R11", 3'b111);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule